// File: doc/BRIEF.md
# Bus-Programmed Watchdog with Sticky Enable

This block is a watchdog timer for a system-on-chip. Software reaches it through a small register bus: one select, one write strobe, a byte address and a 32-bit data word. Writes take effect at the clock edge that samples them. A read returns its data one clock later on a registered read port.

After software arms the watchdog, a down-counter runs on every clock. Software must keep writing a fixed key word to the restart register. If the counter reaches zero first, the block drives a fixed-width pulse on its system reset output, reloads and keeps running.

The period is a power of two taken from a 4-bit select. A second 4-bit select sets the period for the very first countdown only. Nothing in software can disarm the timer; only the block's own reset can.

Top module: `sentry_wdt`

## Requirements
- R1: The four registers decode at byte addresses control 0x00, timeout range 0x04, live count 0x08 and restart 0x0C. A read of the restart register or of any other address returns 0.
- R2: Bit 0 of the control register is the arm bit, and a read shows it. Once set, no write clears it.
- R3: After reset the arm bit and both selects are 0, the count reads 0xFFFF_FFFF and the system reset output is low.
- R4: The timeout range register holds the reload select in bits [3:0] and the first-load select in bits [7:4]; higher bits read 0. It may be written at any time, and a write does not reload the counter.
- R5: A select value i gives a load of 2^(BASE_EXP+i) cycles; BASE_EXP defaults to 16.
- R6: While armed, the counter drops by one per clock. A read of 0x08 returns the counter value at the edge that samples the read.
- R7: Only a write of the full word 0x0000_0076 to the restart register reloads the counter with the reload-select period, and only while armed. Any other value, or any write before arming, has no effect.
- R8: When the counter is zero and armed, with no restart at that edge, the reset output goes high at the next edge and stays high for exactly PULSE_LEN (8) cycles.
- R9: At that expiry edge the counter reloads with the reload-select period, and the arm bit stays set.
- R10: The write that first arms the timer loads the first-load-select period. Writing 1 again while armed leaves the counter running.
- R11: The reset output never goes high while the timer is not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wdt_rst_o | output | 1 | System reset pulse |

## Verification
A wrong count or a wrong reload select shows up on the next read of 0x08, one cycle after the read is issued. It also moves the first edge of the reset pulse by the size of the error. A lost arm bit shows up on the next control read, and it also stops all later pulses. A mis-sized pulse stretcher shows at the falling edge of the reset output, PULSE_LEN cycles after its rise. The bench measures that edge to the cycle, with the period shrunk through BASE_EXP.

// File: rtl/sentry_pkg.sv
package sentry_pkg;
  localparam int BUS_DW = 32;
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_RANGE = 'h04;
  localparam int OFS_COUNT = 'h08;
  localparam int OFS_KICK  = 'h0C;
  localparam logic [BUS_DW-1:0] KICK_WORD = 32'h0000_0076;

  typedef enum logic [2:0] {
    REG_CTRL,
    REG_RANGE,
    REG_COUNT,
    REG_KICK,
    REG_NONE
  } reg_sel_e;
endpackage

// File: rtl/sentry_regs.sv
module sentry_regs
  import sentry_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SEL_W  = 4,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  output logic              en_o,
  output logic [SEL_W-1:0]  top_o,
  output logic [SEL_W-1:0]  topinit_o,
  output logic              start_o,
  output logic              kick_o,
  output logic [BUS_DW-1:0] rdata_o
);
  reg_sel_e            rsel;
  logic                en_q;
  logic [SEL_W-1:0]    top_q, topinit_q;
  logic [BUS_DW-1:0]   rdata_q, rd_mux;
  logic                wr;

  always_comb begin
    if (bus_addr == ADDR_W'(OFS_CTRL))       rsel = REG_CTRL;
    else if (bus_addr == ADDR_W'(OFS_RANGE)) rsel = REG_RANGE;
    else if (bus_addr == ADDR_W'(OFS_COUNT)) rsel = REG_COUNT;
    else if (bus_addr == ADDR_W'(OFS_KICK))  rsel = REG_KICK;
    else                                     rsel = REG_NONE;
  end

  assign wr      = bus_sel & bus_we;
  assign start_o = wr & (rsel == REG_CTRL) & bus_wdata[0] & ~en_q;
  assign kick_o  = wr & (rsel == REG_KICK) & (bus_wdata == KICK_WORD) & en_q;

  always_comb begin
    case (rsel)
      REG_CTRL:  rd_mux = BUS_DW'(en_q);
      REG_RANGE: rd_mux = BUS_DW'({topinit_q, top_q});
      REG_COUNT: rd_mux = BUS_DW'(cnt_val);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      top_q     <= '0;
      topinit_q <= '0;
      rdata_q   <= '0;
    end else begin
      if (start_o) en_q <= 1'b1;
      if (wr && rsel == REG_RANGE) begin
        top_q     <= bus_wdata[SEL_W-1:0];
        topinit_q <= bus_wdata[2*SEL_W-1:SEL_W];
      end
      if (bus_sel && !bus_we) rdata_q <= rd_mux;
    end
  end

  assign en_o      = en_q;
  assign top_o     = top_q;
  assign topinit_o = topinit_q;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/sentry_count.sv
module sentry_count #(
  parameter int CNT_W    = 32,
  parameter int SEL_W    = 4,
  parameter int BASE_EXP = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start,
  input  logic             kick,
  input  logic [SEL_W-1:0] top,
  input  logic [SEL_W-1:0] topinit,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam int NSEL = 1 << SEL_W;

  logic [CNT_W-1:0] load_tbl [NSEL];
  logic [CNT_W-1:0] cnt_q;

  for (genvar i = 0; i < NSEL; i++) begin : g_load
    if (BASE_EXP + i < CNT_W) begin : g_fit
      assign load_tbl[i] = CNT_W'(1) << (BASE_EXP + i);
    end else begin : g_sat
      assign load_tbl[i] = '1;
    end
  end

  assign expire_o = en & ~kick & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)                    cnt_q <= '1;
    else if (start)             cnt_q <= load_tbl[topinit];
    else if (kick || expire_o)  cnt_q <= load_tbl[top];
    else if (en)                cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sentry_pulse.sv
module sentry_pulse #(
  parameter int PULSE_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse_o
);
  localparam int PLS_W = $clog2(PULSE_LEN + 1);

  logic [PLS_W-1:0] left_q;
  logic             out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      out_q  <= 1'b0;
    end else if (fire) begin
      left_q <= PLS_W'(PULSE_LEN);
      out_q  <= 1'b1;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
      out_q  <= (left_q != PLS_W'(1));
    end
  end

  assign pulse_o = out_q;
endmodule

// File: rtl/sentry_wdt.sv
module sentry_wdt
  import sentry_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 32,
  parameter int SEL_W     = 4,
  parameter int BASE_EXP  = 16,
  parameter int PULSE_LEN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdt_rst_o
);
  logic             en_w, start_w, kick_w, expire_w;
  logic [SEL_W-1:0] top_w, topinit_w;
  logic [CNT_W-1:0] cnt_w;

  sentry_regs #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_val(cnt_w),
    .en_o(en_w), .top_o(top_w), .topinit_o(topinit_w),
    .start_o(start_w), .kick_o(kick_w), .rdata_o(bus_rdata)
  );

  sentry_count #(.CNT_W(CNT_W), .SEL_W(SEL_W), .BASE_EXP(BASE_EXP)) u_count (
    .clk(clk), .rst(rst), .en(en_w), .start(start_w), .kick(kick_w),
    .top(top_w), .topinit(topinit_w), .cnt_o(cnt_w), .expire_o(expire_w)
  );

  sentry_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst(rst), .fire(expire_w), .pulse_o(wdt_rst_o)
  );
endmodule

// File: rtl/sentry_chk.sv
module sentry_chk #(
  parameter int CNT_W     = 32,
  parameter int SEL_W     = 4,
  parameter int BASE_EXP  = 16,
  parameter int PULSE_LEN = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             kick,
  input logic [SEL_W-1:0] top,
  input logic [CNT_W-1:0] cnt,
  input logic             rst_out
);
  logic [15:0] hi_len;

  always_ff @(posedge clk) begin
    if (rst)          hi_len <= '0;
    else if (rst_out) hi_len <= hi_len + 1'b1;
    else              hi_len <= '0;
  end

  function automatic logic [CNT_W-1:0] load_of(input logic [SEL_W-1:0] s);
    return CNT_W'(1) << (BASE_EXP + int'(s));
  endfunction

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (rst) en |=> en); // R2
  AST_CNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (en && cnt != '0 && !kick) |=> cnt == $past(cnt) - 1'b1); // R6
  AST_KICK_RELOAD: assert property (@(posedge clk) disable iff (rst)
    kick |=> cnt == load_of($past(top))); // R7
  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_out) |-> $past(en && cnt == '0)); // R8
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_out) |-> hi_len == 16'(PULSE_LEN)); // R8
  AST_EXPIRE_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (en && cnt == '0 && !kick) |=> (en && cnt == load_of($past(top)))); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |-> !rst_out); // R11
endmodule

bind sentry_wdt sentry_chk #(
  .CNT_W(CNT_W), .SEL_W(SEL_W), .BASE_EXP(BASE_EXP), .PULSE_LEN(PULSE_LEN)
) u_chk (
  .clk(clk), .rst(rst), .en(en_w), .kick(kick_w), .top(top_w),
  .cnt(cnt_w), .rst_out(wdt_rst_o)
);

// File: tb/sim_sentry_wdt.sv
module sim_sentry_wdt;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_rst_o;
  int          n_chk = 0;
  int          n_err = 0;

  always #2 clk = ~clk;

  sentry_wdt #(.BASE_EXP(4)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_rst_o(wdt_rst_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus access = one clock edge; called at a negedge, returns at the next
  task automatic bus(input logic we, input logic [7:0] a, input logic [31:0] d,
                     output logic [31:0] rd);
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    rd = bus_rdata;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] unused;
    bus(1'b1, a, d, unused);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus(1'b0, a, '0, v);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R3 reset output low", 32'(wdt_rst_o), 0);
    rd(8'h00, v); chk("R3 arm bit clear", v, 0);
    rd(8'h04, v); chk("R3 selects zero", v, 0);
    rd(8'h08, v); chk("R3 count all ones", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_idle;
    logic [31:0] v;
    int bad = 0;
    wr(8'h0C, 32'h76);
    rd(8'h08, v); chk("R7 kick before arm ignored", v, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R7 kick before arm leaves arm bit", v, 0);
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); @(negedge clk);
      if (wdt_rst_o) bad++;
    end
    chk("R11 no pulse while disarmed", 32'(bad), 0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    wr(8'h04, 32'hFFFF_FF21);
    rd(8'h04, v); chk("R4 range fields and upper bits", v, 32'h21);
    rd(8'h0C, v); chk("R1 restart reads zero", v, 0);
    rd(8'h10, v); chk("R1 unmapped reads zero", v, 0);
  endtask

  // arm with first-load select 2 (64 cycles) and reload select 1 (32 cycles)
  task automatic t_arm;
    logic [31:0] v;
    wr(8'h00, 32'h1);                                        // E0
    rd(8'h08, v); chk("R10 first load from first-load select", v, 64); // E0+1
    rd(8'h00, v); chk("R2 arm bit reads 1", v, 1);                      // E0+2
    wr(8'h00, 32'h0);                                        // E0+3
    wr(8'h00, 32'h1);                                        // E0+4
    rd(8'h00, v); chk("R2 arm bit survives clear", v, 1);               // E0+5
    wr(8'h0C, 32'h75);                                       // E0+6
    wr(8'h0C, 32'h176);                                      // E0+7
    rd(8'h08, v); chk("R6 R7 R10 bad keys and re-arm do not reload", v, 57); // E0+8
    wr(8'h0C, 32'h76);                                       // E0+9
    rd(8'h08, v); chk("R7 R5 key reloads from reload select", v, 32);   // E0+10
  endtask

  task automatic t_retop;
    logic [31:0] v;
    wr(8'h0C, 32'h76);                                       // A: 32
    wr(8'h04, 32'h30);                                       // A+1
    rd(8'h08, v); chk("R4 range write does not reload", v, 31);         // A+2
    wr(8'h0C, 32'h76);                                       // A+3: 16
    rd(8'h08, v); chk("R5 select 0 gives 2^BASE_EXP", v, 16);           // A+4
    rd(8'h04, v); chk("R4 range written while armed", v, 32'h30);
    wr(8'h04, 32'h21);
  endtask

  task automatic t_expire;
    logic [31:0] v;
    int bad = 0;
    wr(8'h0C, 32'h76);                                       // K: 32
    for (int i = 1; i <= 32; i++) begin
      @(posedge clk); @(negedge clk);
      if (wdt_rst_o) bad++;
    end
    chk("R8 no pulse before expiry", 32'(bad), 0);
    @(posedge clk); @(negedge clk);                          // K+33
    chk("R8 pulse rises after zero", 32'(wdt_rst_o), 1);
    bad = 0;
    for (int i = 0; i < 7; i++) begin
      @(posedge clk); @(negedge clk);
      if (!wdt_rst_o) bad++;
    end
    chk("R8 pulse held 8 cycles", 32'(bad), 0);
    @(posedge clk); @(negedge clk);                          // K+41
    chk("R8 pulse ends after 8 cycles", 32'(wdt_rst_o), 0);
    rd(8'h08, v); chk("R9 reload from reload select", v, 24); // K+42
    rd(8'h00, v); chk("R9 arm bit stays set", v, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog all-requirements actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_idle();
    t_map();
    t_arm();
    t_retop();
    t_expire();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule